// File: doc/BRIEF.md
# Three-Bank Event Interrupt Aggregator

The aggregator collects single-cycle event pulses from up to 96 sources and holds them in three 32-bit pending banks. Every event carries a 7-bit number. The upper two bits pick the bank and the lower five bits pick the bit position. Each pending bit fans out to three output lines, A, B and C. Each line has its own mask register per bank. A line is raised while any bank holds a pending bit that is also enabled in that line's mask for the same bank.

The outputs are level signals and are meant for three interrupt priority levels: A for level 13, B for level 11 and C for level 9. Software reaches the pending and mask registers through a simple word-addressed register bus. Writing ones to a pending register acknowledges those events. Bit 0 of bank 0 is a sticky status bit that software can never acknowledge. After every acknowledge, all three outputs are recomputed over the whole pending and mask state.

Register map. Byte address bits [5:4] select the register kind: 0 = pending, 1 = mask A, 2 = mask B, 3 = mask C. Bits [3:2] select the bank. Bits [1:0] and bits [7:6] must be zero. Read data appears on `bus_rdata` one clock after `bus_rd` is sampled high. Outputs are registered. They follow the pending and mask state one clock after that state changes.

Top module: `evt_irq_aggregator`

## Requirements
- R1: Reset clears every pending and mask bit. It also drives `irq_out` and `bus_rdata` to zero.
- R2: A strobe with `evt_valid` high and number N sets bit N[4:0] of pending bank N[6:5]. The bit is visible in a read on the following cycle.
- R3: An event whose bank field N[6:5] equals 3 changes no pending bit.
- R4: A write to pending bank b (address 0x00 + 4·b) clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R5: Bit 0 of pending bank 0 is never cleared by a software write. Only reset clears it.
- R6: `irq_out[0]` (line A), `irq_out[1]` (line B) and `irq_out[2]` (line C) each go high one clock after some bank holds a pending bit that is set in that line's mask for the same bank. The masks are at 0x10, 0x20 and 0x30 + 4·b.
- R7: After an acknowledge, a line stays high while a masked pending bit remains in any bank. It drops one clock after the last such bit is gone.
- R8: A mask write that enables an already pending bit raises the line one clock later, with no new event.
- R9: When an event sets a bit in the same cycle that a software write clears that bit, the bit ends up set. Other bits in the write are still cleared.
- R10: Mask registers read back the value written. A write is ignored, and a read returns 0, when the address has bank field 3, nonzero bits [7:6], or nonzero bits [1:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_valid | input | 1 | Event strobe, one cycle per event |
| evt_num | input | 7 | Event number: [6:5] bank, [4:0] bit |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data (ones clear bits on pending registers) |
| bus_rdata | output | 32 | Registered read data |
| irq_out | output | 3 | Level outputs: [0] line A, [1] line B, [2] line C |

## Verification
The hardest case to reach is a collision: a software acknowledge and a new event landing on the same pending bit in the same clock. The bench drives the event strobe and the bus write from one task in a single cycle. It covers a collision on a bit that was clear and on one that was already set. It also covers an acknowledge that carries other bits alongside the colliding one. A second awkward case is a line that must stay up after an acknowledge because a different bank still holds a masked bit. The bench reaches it by setting up two banks that feed line A, then acknowledging them one at a time.

// File: rtl/evtagg_pkg.sv
package evtagg_pkg;

  // Register kinds selected by address bits [5:4]
  typedef enum logic [1:0] {
    KIND_PEND  = 2'd0,
    KIND_MASKA = 2'd1,
    KIND_MASKB = 2'd2,
    KIND_MASKC = 2'd3
  } reg_kind_e;

  localparam int KIND_LSB = 4;
  localparam int BANK_LSB = 2;
  localparam int FIELD_W  = 2;

endpackage

// File: rtl/evt_decode.sv
module evt_decode #(
  parameter int NUM_BANKS  = 3,
  parameter int BANK_SEL_W = 2,
  parameter int BIT_SEL_W  = 5,
  localparam int BANK_W    = 1 << BIT_SEL_W
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 evt_valid,
  input  logic [BANK_SEL_W+BIT_SEL_W-1:0]      evt_num,
  output logic [NUM_BANKS-1:0][BANK_W-1:0]     set_vec
);

  logic [BANK_SEL_W-1:0] bank_f;
  logic [BIT_SEL_W-1:0]  bit_f;

  assign bank_f = evt_num[BANK_SEL_W+BIT_SEL_W-1:BIT_SEL_W];
  assign bit_f  = evt_num[BIT_SEL_W-1:0];

  always_comb begin
    set_vec = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (evt_valid && bank_f == BANK_SEL_W'(b))
        set_vec[b][bit_f] = 1'b1;
    end
  end

  // R2
  dec_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(set_vec));

  // R3
  dec_unused_bank_chk: assert property (@(posedge clk) disable iff (rst)
    (int'(bank_f) >= NUM_BANKS) |-> (set_vec == '0));

endmodule

// File: rtl/pend_bank.sv
module pend_bank #(
  parameter int BANK_W   = 32,
  parameter bit PROT_EN  = 1'b0,
  parameter int PROT_BIT = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BANK_W-1:0] set_bits,
  input  logic [BANK_W-1:0] clr_bits,
  output logic [BANK_W-1:0] pend
);

  localparam logic [BANK_W-1:0] PROT_MASK =
    PROT_EN ? (BANK_W'(1) << PROT_BIT) : '0;

  logic [BANK_W-1:0] clr_eff;
  assign clr_eff = clr_bits & ~PROT_MASK;

  // Set has priority over clear for the same bit
  always_ff @(posedge clk) begin
    if (rst) pend <= '0;
    else     pend <= (pend & ~clr_eff) | set_bits;
  end

  // R2
  pend_set_chk: assert property (@(posedge clk) disable iff (rst)
    (set_bits != '0) |=> ((pend & $past(set_bits)) == $past(set_bits)));

  // R4
  pend_clr_chk: assert property (@(posedge clk) disable iff (rst)
    ((clr_bits & ~set_bits & ~PROT_MASK) != '0) |=>
      ((pend & $past(clr_bits & ~set_bits & ~PROT_MASK)) == '0));

  // R9
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    ((set_bits & clr_bits) != '0) |=>
      ((pend & $past(set_bits & clr_bits)) == $past(set_bits & clr_bits)));

  generate
    if (PROT_EN) begin : g_prot
      // R5
      prot_hold_chk: assert property (@(posedge clk) disable iff (rst)
        pend[PROT_BIT] |=> pend[PROT_BIT]);
    end
  endgenerate

endmodule

// File: rtl/mask_file.sv
module mask_file #(
  parameter int NUM_BANKS = 3,
  parameter int NUM_LINES = 3,
  parameter int BANK_W    = 32
) (
  input  logic                                         clk,
  input  logic                                         rst,
  input  logic                                         wr_en,
  input  logic [1:0]                                   wr_line,
  input  logic [1:0]                                   wr_bank,
  input  logic [BANK_W-1:0]                            wr_data,
  output logic [NUM_LINES-1:0][NUM_BANKS-1:0][BANK_W-1:0] masks
);

  generate
    for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
      for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        always_ff @(posedge clk) begin
          if (rst)
            masks[l][b] <= '0;
          else if (wr_en && wr_line == 2'(l) && wr_bank == 2'(b))
            masks[l][b] <= wr_data;
        end
      end
    end
  endgenerate

  // R10
  mask_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(masks));

endmodule

// File: rtl/irq_combine.sv
module irq_combine #(
  parameter int NUM_BANKS = 3,
  parameter int NUM_LINES = 3,
  parameter int BANK_W    = 32
) (
  input  logic                                            clk,
  input  logic                                            rst,
  input  logic [NUM_BANKS-1:0][BANK_W-1:0]                pend,
  input  logic [NUM_LINES-1:0][NUM_BANKS-1:0][BANK_W-1:0] masks,
  output logic [NUM_LINES-1:0]                            irq
);

  logic [NUM_LINES-1:0] hit;

  generate
    for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
      logic [NUM_BANKS-1:0] bank_hit;
      for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        assign bank_hit[b] = |(pend[b] & masks[l][b]);
      end
      assign hit[l] = |bank_hit;

      always_ff @(posedge clk) begin
        if (rst) irq[l] <= 1'b0;
        else     irq[l] <= hit[l];
      end

      // R6
      irq_rise_chk: assert property (@(posedge clk) disable iff (rst)
        hit[l] |=> irq[l]);

      // R7
      irq_fall_chk: assert property (@(posedge clk) disable iff (rst)
        !hit[l] |=> !irq[l]);
    end
  endgenerate

endmodule

// File: rtl/evt_irq_aggregator.sv
module evt_irq_aggregator
  import evtagg_pkg::*;
#(
  parameter int NUM_BANKS  = 3,   // at most 4: bank field in the map is 2 bits
  parameter int NUM_LINES  = 3,   // at most 3: kinds 1..3 of the map
  parameter int BANK_SEL_W = 2,
  parameter int BIT_SEL_W  = 5,
  parameter int ADDR_W     = 8,
  parameter int PROT_BANK  = 0,
  parameter int PROT_BIT   = 0
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic                                  evt_valid,
  input  logic [BANK_SEL_W+BIT_SEL_W-1:0]       evt_num,
  input  logic                                  bus_wr,
  input  logic                                  bus_rd,
  input  logic [ADDR_W-1:0]                     bus_addr,
  input  logic [(1<<BIT_SEL_W)-1:0]             bus_wdata,
  output logic [(1<<BIT_SEL_W)-1:0]             bus_rdata,
  output logic [NUM_LINES-1:0]                  irq_out
);

  localparam int BANK_W = 1 << BIT_SEL_W;
  localparam int TOP_LSB = KIND_LSB + FIELD_W;

  logic [NUM_BANKS-1:0][BANK_W-1:0]                set_all, clr_all, pend_all;
  logic [NUM_LINES-1:0][NUM_BANKS-1:0][BANK_W-1:0] masks;

  // ---- address decode ----
  reg_kind_e          kind;
  logic [FIELD_W-1:0] bank_sel;
  logic [FIELD_W-1:0] line_sel;
  logic               addr_ok;

  assign kind     = reg_kind_e'(bus_addr[KIND_LSB +: FIELD_W]);
  assign bank_sel = bus_addr[BANK_LSB +: FIELD_W];
  assign line_sel = bus_addr[KIND_LSB +: FIELD_W] - 2'd1;
  assign addr_ok  = (bus_addr[BANK_LSB-1:0] == '0) &&
                    (bus_addr[ADDR_W-1:TOP_LSB] == '0) &&
                    (int'(bank_sel) < NUM_BANKS) &&
                    (kind == KIND_PEND || int'(line_sel) < NUM_LINES);

  // ---- event decode ----
  evt_decode #(
    .NUM_BANKS (NUM_BANKS),
    .BANK_SEL_W(BANK_SEL_W),
    .BIT_SEL_W (BIT_SEL_W)
  ) u_decode (
    .clk      (clk),
    .rst      (rst),
    .evt_valid(evt_valid),
    .evt_num  (evt_num),
    .set_vec  (set_all)
  );

  // ---- pending banks ----
  generate
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_pend
      assign clr_all[b] = (bus_wr && addr_ok && kind == KIND_PEND &&
                           bank_sel == FIELD_W'(b)) ? bus_wdata : '0;

      pend_bank #(
        .BANK_W  (BANK_W),
        .PROT_EN (b == PROT_BANK),
        .PROT_BIT(PROT_BIT)
      ) u_bank (
        .clk     (clk),
        .rst     (rst),
        .set_bits(set_all[b]),
        .clr_bits(clr_all[b]),
        .pend    (pend_all[b])
      );
    end
  endgenerate

  // ---- mask registers ----
  mask_file #(
    .NUM_BANKS(NUM_BANKS),
    .NUM_LINES(NUM_LINES),
    .BANK_W   (BANK_W)
  ) u_masks (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (bus_wr && addr_ok && kind != KIND_PEND),
    .wr_line(line_sel),
    .wr_bank(bank_sel),
    .wr_data(bus_wdata),
    .masks  (masks)
  );

  // ---- output lines ----
  irq_combine #(
    .NUM_BANKS(NUM_BANKS),
    .NUM_LINES(NUM_LINES),
    .BANK_W   (BANK_W)
  ) u_combine (
    .clk  (clk),
    .rst  (rst),
    .pend (pend_all),
    .masks(masks),
    .irq  (irq_out)
  );

  // ---- registered readback ----
  logic [BANK_W-1:0] rd_sel;

  always_comb begin
    rd_sel = '0;
    if (addr_ok) begin
      if (kind == KIND_PEND) rd_sel = pend_all[bank_sel];
      else                   rd_sel = masks[line_sel][bank_sel];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_sel;
  end

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (irq_out == '0 && bus_rdata == '0));

  // R3
  bank3_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (evt_valid && int'(evt_num[BANK_SEL_W+BIT_SEL_W-1:BIT_SEL_W]) >= NUM_BANKS && !bus_wr)
      |=> $stable(pend_all));

endmodule

// File: tb/test_evt_irq_aggregator.sv
`timescale 1ns/1ps
module test_evt_irq_aggregator;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        evt_valid = 1'b0;
  logic [6:0]  evt_num = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [2:0]  irq_out;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  evt_irq_aggregator i_evt_irq_aggregator (
    .clk(clk), .rst(rst), .evt_valid(evt_valid), .evt_num(evt_num),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out)
  );

  // {event number, expected bank (3 = none), expected bank word}
  localparam logic [40:0] VEC [0:7] = '{
    {7'h01, 2'd0, 32'h0000_0002},
    {7'h1F, 2'd0, 32'h8000_0000},
    {7'h20, 2'd1, 32'h0000_0001},
    {7'h35, 2'd1, 32'h0020_0000},
    {7'h40, 2'd2, 32'h0000_0001},
    {7'h5F, 2'd2, 32'h8000_0000},
    {7'h60, 2'd3, 32'h0000_0000},
    {7'h7F, 2'd3, 32'h0000_0000}
  };

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic raise(logic [6:0] n);
    evt_valid = 1'b1; evt_num = n;
    tick();
    evt_valid = 1'b0;
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    tick();
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    tick();
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic evt_and_clear(logic [6:0] n, logic [7:0] a, logic [31:0] d);
    evt_valid = 1'b1; evt_num = n;
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    tick();
    evt_valid = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic clear_all();
    wr(8'h00, 32'hFFFF_FFFF);
    wr(8'h04, 32'hFFFF_FFFF);
    wr(8'h08, 32'hFFFF_FFFF);
  endtask

  initial begin
    #(4 * 20000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    @(negedge clk); tick(); tick();
    rst = 1'b0;

    // R1 reset state
    chk("R1 irq", {29'd0, irq_out}, 32'd0);
    chk("R1 rdata", bus_rdata, 32'd0);
    rd(8'h00, d); chk("R1 pend0", d, 32'd0);
    rd(8'h14, d); chk("R1 maskA1", d, 32'd0);
    rd(8'h38, d); chk("R1 maskC2", d, 32'd0);

    // R2 / R3 event decode table
    for (int i = 0; i < 8; i++) begin
      clear_all();
      raise(VEC[i][40:34]);
      for (int b = 0; b < 3; b++) begin
        rd(8'(b * 4), d);
        chk((VEC[i][33:32] == 2'd3) ? "R3 unused bank" : "R2 decode", d,
            (int'(VEC[i][33:32]) == b) ? VEC[i][31:0] : 32'd0);
      end
    end
    clear_all();

    // R4 write-one-to-clear
    raise(7'h22); raise(7'h25);
    wr(8'h04, 32'h0000_0004);
    rd(8'h04, d); chk("R4 partial clear", d, 32'h0000_0020);
    wr(8'h04, 32'h0000_0000);
    rd(8'h04, d); chk("R4 zero write", d, 32'h0000_0020);
    clear_all();

    // R10 mask readback and ignored addresses
    wr(8'h14, 32'hA5A5_0003);
    rd(8'h14, d); chk("R10 mask readback", d, 32'hA5A5_0003);
    wr(8'h44, 32'hFFFF_FFFF);
    rd(8'h44, d); chk("R10 high addr", d, 32'd0);
    wr(8'h1C, 32'h1234_5678);
    rd(8'h1C, d); chk("R10 bank3 addr", d, 32'd0);
    wr(8'h15, 32'h0);
    rd(8'h14, d); chk("R10 misaligned", d, 32'hA5A5_0003);
    chk("R10 irq idle", {29'd0, irq_out}, 32'd0);
    wr(8'h14, 32'h0);

    // R6 line assertion per mask set
    wr(8'h18, 32'h0000_0080);
    raise(7'h47); tick();
    chk("R6 line A", {29'd0, irq_out}, 32'h1);
    wr(8'h30, 32'h0000_0008);
    raise(7'h03); tick();
    chk("R6 line C", {29'd0, irq_out}, 32'h5);

    // R7 recompute across banks after clear
    wr(8'h10, 32'h0000_0008); tick();
    chk("R7 setup", {29'd0, irq_out}, 32'h5);
    wr(8'h08, 32'h0000_0080); tick();
    chk("R7 A held by bank0", {29'd0, irq_out}, 32'h5);
    wr(8'h00, 32'h0000_0008); tick();
    chk("R7 all dropped", {29'd0, irq_out}, 32'h0);

    // R8 mask write with no new event
    raise(7'h29); tick();
    chk("R8 unmasked", {29'd0, irq_out}, 32'h0);
    wr(8'h24, 32'h0000_0200); tick();
    chk("R8 mask enables B", {29'd0, irq_out}, 32'h2);
    wr(8'h04, 32'h0000_0200); tick();
    chk("R8 B dropped", {29'd0, irq_out}, 32'h0);

    // R5 protected bit
    wr(8'h10, 32'h0000_0001);
    raise(7'h00); raise(7'h01); tick();
    chk("R5 A raised", {29'd0, irq_out}, 32'h1);
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, d); chk("R5 sticky bit", d, 32'h0000_0001);
    tick();
    chk("R5 A held", {29'd0, irq_out}, 32'h1);

    // R9 set wins over clear
    evt_and_clear(7'h24, 8'h04, 32'h0000_0010);
    rd(8'h04, d); chk("R9 set from clear", d, 32'h0000_0010);
    evt_and_clear(7'h24, 8'h04, 32'h0000_0010);
    rd(8'h04, d); chk("R9 set already", d, 32'h0000_0010);
    evt_and_clear(7'h26, 8'h04, 32'h0000_0010);
    rd(8'h04, d); chk("R9 other bit cleared", d, 32'h0000_0040);

    // R1 reset again clears the sticky bit and masks
    rst = 1'b1; tick(); tick(); rst = 1'b0;
    chk("R1 irq after reset", {29'd0, irq_out}, 32'd0);
    rd(8'h00, d); chk("R1 sticky cleared", d, 32'd0);
    rd(8'h10, d); chk("R1 maskA0 cleared", d, 32'd0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule